// File: doc/BRIEF.md
# Character-Cell Overlay Generator

This block draws a grid of text characters over the active picture. Each clock it receives the pixel position and a valid strobe from the display timing. Two clocks later it returns an overlay-active flag and a 3-bit color index for that pixel. The mixer that merges this overlay with the live video sits downstream.

A host write port loads four things: the character memory (glyph code, colors, invert and blink per cell), the per-row attributes (border color, fringe enable), three configuration registers (grid geometry, horizontal origin, vertical origin) and a small RAM of host-defined glyphs. Cells are 16 pixels wide and 20 lines tall. The grid can be 24 by 8, 24 by 10 or 32 by 8 cells.

Glyph codes are 9 bits. Codes 0 to 500 select built-in glyphs, which use a computed placeholder pattern. Codes 501 to 508 select the eight host-defined glyphs.

Top module: `char_osd`

## Requirements
- R1: `osd_active` is 1 only for a pixel with `pix_valid` high that lies inside the window. The window starts at (hstart, vstart) and spans columns×16 pixels by rows×20 lines. For every other pixel, `osd_active` and `osd_color` are both 0.
- R2: The result for a pixel presented at a rising edge appears after the second rising edge that follows. It is not yet visible after the first.
- R3: The configuration registers sit at host addresses 0x400 (geometry, wdata[1:0]), 0x401 (horizontal start) and 0x402 (vertical start). Geometry 0 is 24×8, 1 is 24×10, 2 is 32×8, and 3 behaves like 0.
- R4: Within the window, the cell is row = ry/20 and column = rx/16, with glyph line ry%20 and pixel column rx%16. The cell is stored at host address row*32+column. Its word holds the code in bits [8:0], foreground in [11:9], background in [14:12], invert in bit 15 and blink in bit 16.
- R5: For a built-in code k (0 to 500), the pixel in glyph line l and column c (0 = leftmost) is lit exactly when bit ((c XOR l) AND 7) of k is 1.
- R6: Host-defined glyph g (code 501+g) line l is written at address 0x600 + g*32 + l, with the pixels in wdata[15:0] and bit 15 as the leftmost pixel. Codes 509 to 511 draw no lit pixel.
- R7: A lit pixel takes the foreground color and an unlit pixel takes the background color. When the cell's invert bit is set, the two colors are swapped.
- R8: The attributes for row r are written at address 0x200 + r: border color in wdata[2:0] and fringe enable in wdata[3]. With fringe enabled, an unlit pixel that has a lit pixel directly left, right, above or below it within the same glyph shows the border color.
- R9: The blink phase starts visible. It toggles after every BLINK_FRAMES `frame_start` pulses. In the hidden phase, a cell with its blink bit set shows only its effective background color, with no glyph and no fringe.
- R10: Reset clears both outputs, the blink phase, the row attributes and the configuration registers. After reset the geometry is 24×8 and the origin is (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | XW | Current pixel column |
| pix_y | input | YW | Current pixel line |
| pix_valid | input | 1 | Pixel position is valid |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host write address |
| host_wdata | input | 17 | Host write data |
| osd_active | output | 1 | Overlay covers this pixel |
| osd_color | output | 3 | Overlay color index |

## Verification
The bench builds the block with BLINK_FRAMES set to 4 and every other parameter at its default. This lets the blink phase go hidden and come back with a handful of frame pulses.

With a 250 MHz pixel stream, the bench sweeps each pixel of the 24×8 window, plus a margin on every side, against an arithmetic model. It also sweeps striped line sets in the other geometries, each at a different origin. The cell contents are chosen so that built-in, host-defined, blank and full glyphs all appear, along with inverted and blinking cells and rows with and without fringe. This exposes every edge of the window, the neighbour rules for fringe pixels, and the glyph-line boundaries at lines 0 and 19.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
package osd_pkg;
  localparam int CODE_W  = 9;
  localparam int COLOR_W = 3;

  typedef struct packed {
    logic               blink;
    logic               inv;
    logic [COLOR_W-1:0] bg;
    logic [COLOR_W-1:0] fg;
    logic [CODE_W-1:0]  code;
  } cell_t;

  typedef struct packed {
    logic               fringe;
    logic [COLOR_W-1:0] border;
  } rowattr_t;

  localparam int HOST_DW = $bits(cell_t);

  typedef enum logic [1:0] {
    RG_CHAR = 2'd0,
    RG_ROW  = 2'd1,
    RG_CFG  = 2'd2,
    RG_USER = 2'd3
  } region_e;
endpackage

// File: rtl/osd_blink.sv
`timescale 1ns/1ps
module osd_blink #(
  parameter int BLINK_FRAMES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic off_phase
);
  localparam int CNTW = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(BLINK_FRAMES - 1);

  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      off_phase <= 1'b0;
    end else if (frame_start) begin
      if (cnt == LAST) begin
        cnt       <= '0;
        off_phase <= ~off_phase;
      end else begin
        cnt <= cnt + CNTW'(1);
      end
    end
  end

  // R9: the phase only moves on a frame pulse
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start) |-> $stable(off_phase));
endmodule

// File: rtl/osd_store.sv
`timescale 1ns/1ps
module osd_store
  import osd_pkg::*;
#(
  parameter int AW          = 11,
  parameter int XW          = 11,
  parameter int YW          = 10,
  parameter int CELL_W      = 16,
  parameter int COL_SLOTS   = 32,
  parameter int ROW_SLOTS   = 16,
  parameter int USER_GLYPHS = 8,
  parameter int LINE_SLOTS  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [HOST_DW-1:0]     wdata,
  input  logic [$clog2(ROW_SLOTS)-1:0] rd_row,
  input  logic [$clog2(COL_SLOTS)-1:0] rd_col,
  input  logic [$clog2(USER_GLYPHS)+$clog2(LINE_SLOTS)-1:0] ug_ra [3],
  output logic [CELL_W-1:0]      ug_rd [3],
  output cell_t                  cell_q,
  output rowattr_t               rattr_q,
  output logic [1:0]             mode_q,
  output logic [XW-1:0]          hstart_q,
  output logic [YW-1:0]          vstart_q
);
  localparam int CAW = $clog2(COL_SLOTS);
  localparam int RAW = $clog2(ROW_SLOTS);
  localparam int UAW = $clog2(USER_GLYPHS) + $clog2(LINE_SLOTS);
  localparam int CM_DEPTH = COL_SLOTS * ROW_SLOTS;
  localparam int UM_DEPTH = 2 ** UAW;

  region_e region;
  assign region = region_e'(addr[AW-1:AW-2]);

  cell_t             cmem [CM_DEPTH];
  logic [CELL_W-1:0] umem [UM_DEPTH];
  rowattr_t          rattr [ROW_SLOTS];
  logic [UAW-1:0]    uwa;
  assign uwa = addr[UAW-1:0];

  always_ff @(posedge clk) begin
    if (we && region == RG_CHAR) cmem[addr[CAW+RAW-1:0]] <= cell_t'(wdata);
    cell_q <= cmem[{rd_row, rd_col}];
  end

  always_ff @(posedge clk) begin
    if (we && region == RG_USER) umem[uwa] <= wdata[CELL_W-1:0];
  end

  generate
    for (genvar k = 0; k < 3; k++) begin : g_urd
      assign ug_rd[k] = umem[ug_ra[k]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROW_SLOTS; i++) rattr[i] <= '0;
      rattr_q  <= '0;
      mode_q   <= '0;
      hstart_q <= '0;
      vstart_q <= '0;
    end else begin
      rattr_q <= rattr[rd_row];
      if (we && region == RG_ROW) rattr[addr[RAW-1:0]] <= rowattr_t'(wdata[3:0]);
      if (we && region == RG_CFG) begin
        case (addr[1:0])
          2'd0:    mode_q   <= wdata[1:0];
          2'd1:    hstart_q <= wdata[XW-1:0];
          2'd2:    vstart_q <= wdata[YW-1:0];
          default: ;
        endcase
      end
    end
  end

  // R3: a geometry write lands in the mode register
  p_cfg_write_r3: assert property (@(posedge clk) disable iff (rst)
    (we && region == RG_CFG && addr[1:0] == 2'd0) |=> mode_q == $past(wdata[1:0]));

  // R6: a glyph-RAM write is held at the addressed line
  p_user_write_r6: assert property (@(posedge clk) disable iff (rst)
    (we && region == RG_USER) |=> umem[$past(uwa)] == $past(wdata[CELL_W-1:0]));
endmodule

// File: rtl/osd_glyph.sv
`timescale 1ns/1ps
module osd_glyph
  import osd_pkg::*;
#(
  parameter int CELL_W      = 16,
  parameter int CELL_H      = 20,
  parameter int USER_GLYPHS = 8,
  parameter int LINE_SLOTS  = 32,
  parameter int FIXED_LAST  = 500
) (
  input  logic [CODE_W-1:0]              code,
  input  logic [$clog2(LINE_SLOTS)-1:0]  line,
  output logic [$clog2(USER_GLYPHS)+$clog2(LINE_SLOTS)-1:0] ug_ra [3],
  input  logic [CELL_W-1:0]              ug_rd [3],
  output logic [CELL_W-1:0]              rows_out [3]
);
  localparam int LW = $clog2(LINE_SLOTS);
  localparam int GW = $clog2(USER_GLYPHS);
  localparam logic [CODE_W-1:0] FIX_LAST_C   = CODE_W'(FIXED_LAST);
  localparam logic [CODE_W-1:0] USER_FIRST_C = CODE_W'(FIXED_LAST + 1);
  localparam logic [CODE_W-1:0] USER_END_C   = CODE_W'(FIXED_LAST + 1 + USER_GLYPHS);
  localparam logic [LW-1:0]     LAST_LINE    = LW'(CELL_H - 1);

  logic          is_fixed, is_user;
  logic [GW-1:0] user_idx;
  logic [LW-1:0] li [3];
  logic          present [3];

  assign is_fixed = code <= FIX_LAST_C;
  assign is_user  = (code >= USER_FIRST_C) && (code < USER_END_C);
  assign user_idx = GW'(code - USER_FIRST_C);

  assign li[0] = line - LW'(1);
  assign li[1] = line;
  assign li[2] = line + LW'(1);
  assign present[0] = line != '0;
  assign present[1] = 1'b1;
  assign present[2] = line != LAST_LINE;

  generate
    for (genvar k = 0; k < 3; k++) begin : g_line
      logic [CELL_W-1:0] fix;
      for (genvar c = 0; c < CELL_W; c++) begin : g_px
        logic [2:0] sel;
        assign sel = 3'(c) ^ li[k][2:0];
        assign fix[CELL_W-1-c] = code[sel];
      end
      assign ug_ra[k]    = {user_idx, li[k]};
      assign rows_out[k] = !present[k] ? '0 :
                           is_fixed    ? fix :
                           is_user     ? ug_rd[k] : '0;
    end
  endgenerate
endmodule

// File: rtl/char_osd.sv
`timescale 1ns/1ps
module char_osd
  import osd_pkg::*;
#(
  parameter int XW           = 11,
  parameter int YW           = 10,
  parameter int AW           = 11,
  parameter int CELL_W       = 16,
  parameter int CELL_H       = 20,
  parameter int NARROW_COLS  = 24,
  parameter int WIDE_COLS    = 32,
  parameter int SHORT_ROWS   = 8,
  parameter int TALL_ROWS    = 10,
  parameter int USER_GLYPHS  = 8,
  parameter int FIXED_LAST   = 500,
  parameter int BLINK_FRAMES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XW-1:0]      pix_x,
  input  logic [YW-1:0]      pix_y,
  input  logic               pix_valid,
  input  logic               frame_start,
  input  logic               host_we,
  input  logic [AW-1:0]      host_addr,
  input  logic [16:0]        host_wdata,
  output logic               osd_active,
  output logic [2:0]         osd_color
);
  localparam int COL_SLOTS  = 2 ** $clog2(WIDE_COLS);
  localparam int ROW_SLOTS  = 2 ** $clog2(TALL_ROWS);
  localparam int LINE_SLOTS = 2 ** $clog2(CELL_H);
  localparam int CAW = $clog2(COL_SLOTS);
  localparam int RAW = $clog2(ROW_SLOTS);
  localparam int LW  = $clog2(LINE_SLOTS);
  localparam int PW  = $clog2(CELL_W);
  localparam int UAW = $clog2(USER_GLYPHS) + LW;
  localparam logic [XW-1:0] CW_X    = XW'(CELL_W);
  localparam logic [YW-1:0] CH_Y    = YW'(CELL_H);
  localparam logic [XW-1:0] W_NARROW = XW'(NARROW_COLS * CELL_W);
  localparam logic [XW-1:0] W_WIDE   = XW'(WIDE_COLS * CELL_W);
  localparam logic [YW-1:0] H_SHORT  = YW'(SHORT_ROWS * CELL_H);
  localparam logic [YW-1:0] H_TALL   = YW'(TALL_ROWS * CELL_H);
  localparam logic [CELL_W-1:0] MSB_ONLY = {1'b1, {(CELL_W-1){1'b0}}};

  cell_t             cell_q;
  rowattr_t          rattr_q;
  logic [1:0]        mode_q;
  logic [XW-1:0]     hstart_q;
  logic [YW-1:0]     vstart_q;
  logic [UAW-1:0]    ug_ra [3];
  logic [CELL_W-1:0] ug_rd [3];
  logic [CELL_W-1:0] gl [3];
  logic              blink_off;

  // ---- stage 0: window test and cell addressing
  logic [XW-1:0]  rel_x, win_w;
  logic [YW-1:0]  rel_y, win_h;
  logic           in_win;
  logic [CAW-1:0] rd_col;
  logic [RAW-1:0] rd_row;

  assign win_w  = (mode_q == 2'd2) ? W_WIDE : W_NARROW;
  assign win_h  = (mode_q == 2'd1) ? H_TALL : H_SHORT;
  assign rel_x  = pix_x - hstart_q;
  assign rel_y  = pix_y - vstart_q;
  assign in_win = pix_valid && (pix_x >= hstart_q) && (pix_y >= vstart_q) &&
                  (rel_x < win_w) && (rel_y < win_h);
  assign rd_col = CAW'(rel_x / CW_X);
  assign rd_row = RAW'(rel_y / CH_Y);

  osd_store #(
    .AW(AW), .XW(XW), .YW(YW), .CELL_W(CELL_W), .COL_SLOTS(COL_SLOTS),
    .ROW_SLOTS(ROW_SLOTS), .USER_GLYPHS(USER_GLYPHS), .LINE_SLOTS(LINE_SLOTS)
  ) u_store (
    .clk, .rst, .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .rd_row, .rd_col, .ug_ra, .ug_rd, .cell_q, .rattr_q,
    .mode_q, .hstart_q, .vstart_q
  );

  osd_blink #(.BLINK_FRAMES(BLINK_FRAMES)) u_blink (
    .clk, .rst, .frame_start, .off_phase(blink_off)
  );

  logic          s1_act;
  logic [PW-1:0] s1_px;
  logic [LW-1:0] s1_ln;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_act <= 1'b0;
      s1_px  <= '0;
      s1_ln  <= '0;
    end else begin
      s1_act <= in_win;
      s1_px  <= PW'(rel_x % CW_X);
      s1_ln  <= LW'(rel_y % CH_Y);
    end
  end

  // ---- stage 1: glyph lines, attributes, fringe
  osd_glyph #(
    .CELL_W(CELL_W), .CELL_H(CELL_H), .USER_GLYPHS(USER_GLYPHS),
    .LINE_SLOTS(LINE_SLOTS), .FIXED_LAST(FIXED_LAST)
  ) u_glyph (
    .code(cell_q.code), .line(s1_ln), .ug_ra, .ug_rd, .rows_out(gl)
  );

  logic [CELL_W-1:0]  mask;
  logic               lit, near;
  logic [COLOR_W-1:0] fg_e, bg_e, color_c;

  assign mask = MSB_ONLY >> s1_px;
  assign lit  = |(gl[1] & mask);
  assign near = |(gl[1] & (mask << 1)) | |(gl[1] & (mask >> 1)) |
                |(gl[0] & mask) | |(gl[2] & mask);
  assign fg_e = cell_q.inv ? cell_q.bg : cell_q.fg;
  assign bg_e = cell_q.inv ? cell_q.fg : cell_q.bg;

  always_comb begin
    if (cell_q.blink && blink_off)       color_c = bg_e;
    else if (lit)                        color_c = fg_e;
    else if (rattr_q.fringe && near)     color_c = rattr_q.border;
    else                                 color_c = bg_e;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osd_active <= 1'b0;
      osd_color  <= '0;
    end else begin
      osd_active <= s1_act;
      osd_color  <= s1_act ? color_c : '0;
    end
  end

  // R1: no color leaks out while the overlay is idle
  p_idle_dark_r1: assert property (@(posedge clk) disable iff (rst)
    !osd_active |-> osd_color == '0);

  // R2: an active output traces back to a valid pixel two clocks earlier
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    osd_active |-> $past(pix_valid, 2));
endmodule

// File: tb/char_osd_tb.sv
`timescale 1ns/1ps
module char_osd_tb;
  localparam int BF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] pix_x = '0;
  logic [9:0]  pix_y = '0;
  logic        pix_valid = 1'b0;
  logic        frame_start = 1'b0;
  logic        host_we = 1'b0;
  logic [10:0] host_addr = '0;
  logic [16:0] host_wdata = '0;
  logic        osd_active;
  logic [2:0]  osd_color;

  always #2 clk = ~clk;

  char_osd #(.BLINK_FRAMES(BF)) u_dut (
    .clk, .rst, .pix_x, .pix_y, .pix_valid, .frame_start,
    .host_we, .host_addr, .host_wdata, .osd_active, .osd_color
  );

  int errors = 0, checks = 0;
  int mode = 0, hs = 0, vs = 0, frames = 0;
  int cc [10][32], cfg [10][32], cbg [10][32];
  bit cinv [10][32], cblk [10][32];
  int rbd [10];
  bit rfr [10];
  bit [15:0] ug [8][20];

  function automatic bit gbit(int code, int l, int p);
    if (l < 0 || l > 19 || p < 0 || p > 15) return 1'b0;
    if (code <= 500) return bit'((code >> ((p ^ l) & 7)) & 1);
    if (code <= 508) return ug[code-501][l][15-p];
    return 1'b0;
  endfunction

  function automatic int model(int x, int y, bit v);
    int cols, rows, rx, ry, r, c, l, p, code, fg, bg, t;
    bit nb;
    cols = (mode == 2) ? 32 : 24;
    rows = (mode == 1) ? 10 : 8;
    if (!v || x < hs || y < vs) return -1;
    rx = x - hs; ry = y - vs;
    if (rx >= cols*16 || ry >= rows*20) return -1;
    r = ry / 20; c = rx / 16; l = ry % 20; p = rx % 16;
    code = cc[r][c]; fg = cfg[r][c]; bg = cbg[r][c];
    if (cinv[r][c]) begin t = fg; fg = bg; bg = t; end
    if (cblk[r][c] && ((frames / BF) % 2 == 1)) return bg;
    if (gbit(code, l, p)) return fg;
    nb = gbit(code, l, p-1) | gbit(code, l, p+1) | gbit(code, l-1, p) | gbit(code, l+1, p);
    if (rfr[r] && nb) return rbd[r];
    return bg;
  endfunction

  task automatic compare(int exp, string tag);
    bit ok;
    checks++;
    if (exp < 0) ok = (osd_active == 1'b0) && (osd_color == 3'd0);
    else         ok = (osd_active == 1'b1) && (osd_color == 3'(exp));
    if (!ok) begin
      errors++;
      $display("FAIL %s: active=%0b color=%0d expected active=%0b color=%0d",
               tag, osd_active, osd_color, exp >= 0, (exp < 0) ? 0 : exp);
    end
  endtask

  int p1_exp = -1, p2_exp = -1;
  bit p1_chk = 0, p2_chk = 0;
  string p1_tag = "", p2_tag = "";

  task automatic step(int x, int y, bit v, bit chk, string tag);
    @(negedge clk);
    if (p2_chk) compare(p2_exp, p2_tag);
    p2_exp = p1_exp; p2_chk = p1_chk; p2_tag = p1_tag;
    pix_x = 11'(x); pix_y = 10'(y); pix_valid = v;
    p1_exp = model(x, y, v); p1_chk = chk; p1_tag = tag;
  endtask

  task automatic flush();
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
  endtask

  task automatic scan_line(int y, int x0, int x1, string tag);
    for (int x = x0; x <= x1; x++) step(x, y, 1'b1, 1'b1, tag);
    flush();
  endtask

  task automatic hw(int a, int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 11'(a); host_wdata = 17'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_cfg(int m, int h, int v);
    hw(12'h400, m); hw(12'h401, h); hw(12'h402, v);
    mode = m; hs = h; vs = v;
  endtask

  task automatic pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    frames++;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: active=%0b color=%0d expected active=0 color=0 (run ended)",
             osd_active, osd_color);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R10: reset state with a valid pixel present
    pix_valid = 1'b1;
    repeat (4) @(negedge clk);
    compare(-1, "R10 during reset");
    @(negedge clk); rst = 1'b0; pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare(-1, "R10 after reset");

    // contents
    for (int g = 0; g < 8; g++)
      for (int l = 0; l < 20; l++) begin
        ug[g][l] = (16'h1 << ((g + l) % 16)) | (16'h8000 >> l) | ((g == 0) ? 16'hF00F : 16'h0);
        hw(12'h600 + g*32 + l, int'(ug[g][l]));
      end
    for (int r = 0; r < 10; r++) begin
      rbd[r] = (r*5 + 2) % 8; rfr[r] = (r % 2 == 1);
      hw(12'h200 + r, (int'(rfr[r]) << 3) | rbd[r]);
      for (int c = 0; c < 32; c++) begin
        int code;
        code = (r*53 + c*29 + 7) % 512;
        if (c == 3) code = 501 + (r % 8);
        if (c == 9) code = 255;
        if (c == 12) code = 0;
        if (r == 2 && c == 7) code = 509;
        if (r == 4 && c == 5) code = 500;
        cc[r][c] = code; cfg[r][c] = (c + r) % 8; cbg[r][c] = (c*3 + r + 1) % 8;
        cinv[r][c] = ((c + r) % 3 == 0); cblk[r][c] = (c % 5 == 1);
        hw(r*32 + c, (int'(cblk[r][c]) << 16) | (int'(cinv[r][c]) << 15) |
                     (cbg[r][c] << 12) | (cfg[r][c] << 9) | code);
      end
    end

    // R10: default geometry 24x8 at origin (0,0)
    for (int y = 0; y < 3; y++) scan_line(y, 0, 390, "R10 default cfg");
    scan_line(159, 370, 390, "R10 default cfg");
    scan_line(160, 370, 390, "R10 default cfg");

    // R2: latency, one isolated pixel in full-glyph cell (row 0, col 9)
    set_cfg(0, 5, 3);
    flush();
    @(negedge clk); pix_x = 11'(5 + 9*16 + 4); pix_y = 10'(3 + 2); pix_valid = 1'b1;
    p1_exp = model(5 + 9*16 + 4, 5, 1'b1);
    @(negedge clk); pix_valid = 1'b0;
    compare(-1, "R2 one clock after");
    @(negedge clk);
    compare(p1_exp, "R2 two clocks after");
    p1_exp = -1;
    flush();

    // R1 R4 R5 R6 R7 R8: full sweep of 24x8 with margins
    for (int y = 0; y <= 166; y++)
      scan_line(y, 0, 395, "R1 R4 R5 R6 R7 R8 sweep");
    // R1: valid low inside window
    for (int x = 5; x < 60; x++) step(x, 10, 1'b0, 1'b1, "R1 invalid pixel");
    flush();

    // R3: 24x10 geometry at another origin
    set_cfg(1, 17, 1);
    for (int y = 0; y <= 205; y += 5) scan_line(y, 0, 410, "R3 24x10");
    scan_line(200, 0, 410, "R3 24x10 last line");
    scan_line(201, 0, 410, "R3 24x10 below");
    // R3: 32x8 geometry
    set_cfg(2, 2, 7);
    for (int y = 0; y <= 170; y += 7) scan_line(y, 0, 520, "R3 32x8");
    scan_line(166, 0, 520, "R3 32x8 last line");
    scan_line(167, 0, 520, "R3 32x8 below");
    // R3: code 3 behaves like 24x8
    set_cfg(3, 0, 0);
    scan_line(0, 0, 400, "R3 mode3");
    scan_line(159, 0, 400, "R3 mode3");
    scan_line(160, 0, 400, "R3 mode3");

    // R9: blink hidden after BF pulses, visible again after BF more
    set_cfg(0, 5, 3);
    for (int i = 0; i < BF - 1; i++) pulse();
    for (int y = 23; y < 43; y += 2) scan_line(y, 0, 395, "R9 still visible");
    pulse();
    for (int y = 23; y < 43; y++) scan_line(y, 0, 395, "R9 hidden phase");
    for (int i = 0; i < BF; i++) pulse();
    for (int y = 23; y < 43; y += 3) scan_line(y, 0, 395, "R9 visible again");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule